// File: doc/BRIEF.md
# DMA Channel Interrupt Controller

This block gathers the event pulses of one DMA channel's data engine into a sticky status register. It decides which of those events may raise the channel interrupt, and it drives a single level interrupt line. Software reaches it through a plain 32-bit register port with separate read and write strobes and a word address. Status bits are cleared by writing ones to them. The mask cannot be written directly: one write-only port unmasks bits and another masks them.

Two 8-bit accounting counters record completed source and destination descriptors that requested an interrupt. A counter clears when software reads it, so each read returns the number of completions since the previous read. When a counter wraps, the block sets a dedicated error bit so that software knows the count is no longer trustworthy.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset the status register and both counters read 0, the mask reads 0xFFF, `irq` is low and `reg_rdata` is 0.
- R2: Event inputs set status bits, which stay set until cleared: invalid access 0, source descriptor done 1, destination descriptor done 2, byte count overflow 3, source count error 4, destination count error 5, source descriptor read error 6, destination descriptor read error 7, read-data error 8, write-data error 9, done 10, pause 11. The status register reads at word offset 0.
- R3: A write to offset 0 clears each status bit whose data bit is 1 and leaves the others. If an event sets a bit in the same cycle, the bit stays set.
- R4: The mask reads at offset 1 (bits 11:0, 1 = masked). Writes to offset 1 have no effect.
- R5: Writing a 1 to a bit at offset 2 clears that mask bit. Writing a 1 at offset 3 sets it. Offsets 2 and 3 read as 0.
- R6: `irq` is registered. In each cycle it equals the OR over all bits of (status AND NOT mask), taken as that value stood one clock earlier.
- R7: The source counter (offset 4) increments on `ev_src_dscr_done`. The destination counter (offset 5) increments on `ev_dst_dscr_done`. A read returns the count in bits 7:0 and zeroes the counter. A read coinciding with an increment leaves the counter at 1.
- R8: An increment from 255 wraps the counter to 0 and sets status bit 4 (source) or 5 (destination). A read in the same cycle as that increment leaves 1 and sets no error bit.
- R9: A read or write to any offset above 5 sets status bit 0, and the read returns 0.
- R10: Read data appears on `reg_rdata` in the cycle after `reg_rd`. In any other cycle `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| ev_done | input | 1 | Transfer finished |
| ev_pause | input | 1 | Channel paused |
| ev_wr_err | input | 1 | Data write bus error |
| ev_rd_err | input | 1 | Data read bus error |
| ev_src_dscr_err | input | 1 | Source descriptor fetch error |
| ev_dst_dscr_err | input | 1 | Destination descriptor fetch error |
| ev_byte_ovf | input | 1 | Byte count overflow |
| ev_src_dscr_done | input | 1 | Source descriptor done with interrupt flag |
| ev_dst_dscr_done | input | 1 | Destination descriptor done with interrupt flag |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume reset is held for at least two clock edges. They also assume `reg_rd` and `reg_wr` are never high together, because a single shared address would make the cycle's meaning ambiguous. Event inputs are taken as single-cycle qualified levels sampled on each edge, with no handshake. The stimulus drives every input at the falling edge, holds reset for five cycles, and chooses either a read, a write or neither in each random cycle. This keeps the run inside those assumptions. Events fire freely, including in the same cycle as status clears and counter reads.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int ST_W = 12;
  // status bit positions
  localparam int B_INV      = 0;
  localparam int B_SRC_DONE = 1;
  localparam int B_DST_DONE = 2;
  localparam int B_BYTE_OVF = 3;
  localparam int B_SRC_CERR = 4;
  localparam int B_DST_CERR = 5;
  localparam int B_SRC_DERR = 6;
  localparam int B_DST_DERR = 7;
  localparam int B_RD_ERR   = 8;
  localparam int B_WR_ERR   = 9;
  localparam int B_DONE     = 10;
  localparam int B_PAUSE    = 11;
  // word offsets
  localparam int OFF_STATUS  = 0;
  localparam int OFF_MASK    = 1;
  localparam int OFF_UNMASK  = 2;
  localparam int OFF_MASKSET = 3;
  localparam int OFF_SRC_CNT = 4;
  localparam int OFF_DST_CNT = 5;
  localparam int OFF_LAST    = 5;
  localparam int N_CNT       = 2;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           q_o[b] <= 1'b0;
      else if (set_i[b]) q_o[b] <= 1'b1;   // event beats clear
      else if (clr_i[b]) q_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] unmask_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= '1;
    else     q_o <= (q_o & ~unmask_i) | mask_i;
  end
endmodule

// File: rtl/irq_acct_cnt.sv
module irq_acct_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_i,
  input  logic          rd_i,
  output logic [CW-1:0] q_o,
  output logic          wrap_o
);
  assign wrap_o = inc_i & ~rd_i & (&q_o);

  always_ff @(posedge clk) begin
    if (rst)        q_o <= '0;
    else if (rd_i)  q_o <= {{(CW-1){1'b0}}, inc_i};
    else if (inc_i) q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_done,
  input  logic              ev_pause,
  input  logic              ev_wr_err,
  input  logic              ev_rd_err,
  input  logic              ev_src_dscr_err,
  input  logic              ev_dst_dscr_err,
  input  logic              ev_byte_ovf,
  input  logic              ev_src_dscr_done,
  input  logic              ev_dst_dscr_done,
  output logic              irq
);
  logic [ST_W-1:0]  status_q, mask_q, st_set, st_clr, mk_clr, mk_set;
  logic [CNT_W-1:0] cnt_q [N_CNT];
  logic [N_CNT-1:0] cnt_inc, cnt_rd, cnt_wrap;
  logic             acc, unmapped;
  logic [DATA_W-1:0] rdata_d;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:ST_W];

  // ---------------- decode ----------------
  assign acc      = reg_wr | reg_rd;
  assign unmapped = reg_addr > ADDR_W'(OFF_LAST);

  always_comb begin
    st_clr = (reg_wr && reg_addr == ADDR_W'(OFF_STATUS))  ? reg_wdata[ST_W-1:0] : '0;
    mk_clr = (reg_wr && reg_addr == ADDR_W'(OFF_UNMASK))  ? reg_wdata[ST_W-1:0] : '0;
    mk_set = (reg_wr && reg_addr == ADDR_W'(OFF_MASKSET)) ? reg_wdata[ST_W-1:0] : '0;
    for (int i = 0; i < N_CNT; i++)
      cnt_rd[i] = reg_rd && (reg_addr == ADDR_W'(OFF_SRC_CNT + i));
  end

  assign cnt_inc = {ev_dst_dscr_done, ev_src_dscr_done};

  always_comb begin
    st_set             = '0;
    st_set[B_INV]      = acc & unmapped;
    st_set[B_SRC_DONE] = ev_src_dscr_done;
    st_set[B_DST_DONE] = ev_dst_dscr_done;
    st_set[B_BYTE_OVF] = ev_byte_ovf;
    st_set[B_SRC_CERR] = cnt_wrap[0];
    st_set[B_DST_CERR] = cnt_wrap[1];
    st_set[B_SRC_DERR] = ev_src_dscr_err;
    st_set[B_DST_DERR] = ev_dst_dscr_err;
    st_set[B_RD_ERR]   = ev_rd_err;
    st_set[B_WR_ERR]   = ev_wr_err;
    st_set[B_DONE]     = ev_done;
    st_set[B_PAUSE]    = ev_pause;
  end

  // ---------------- state ----------------
  irq_status_reg #(.W(ST_W)) u_status (
    .clk(clk), .rst(rst), .set_i(st_set), .clr_i(st_clr), .q_o(status_q)
  );

  irq_mask_reg #(.W(ST_W)) u_mask (
    .clk(clk), .rst(rst), .unmask_i(mk_clr), .mask_i(mk_set), .q_o(mask_q)
  );

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    irq_acct_cnt #(.CW(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .inc_i(cnt_inc[g]), .rd_i(cnt_rd[g]),
      .q_o(cnt_q[g]), .wrap_o(cnt_wrap[g])
    );
  end

  // ---------------- read path ----------------
  always_comb begin
    rdata_d = '0;
    if (reg_rd) begin
      if (reg_addr == ADDR_W'(OFF_STATUS))       rdata_d = DATA_W'(status_q);
      else if (reg_addr == ADDR_W'(OFF_MASK))    rdata_d = DATA_W'(mask_q);
      else if (cnt_rd[0])                        rdata_d = DATA_W'(cnt_q[0]);
      else if (cnt_rd[1])                        rdata_d = DATA_W'(cnt_q[1]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      reg_rdata <= rdata_d;
      irq       <= |(status_q & ~mask_q);
    end
  end
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  parameter int SW     = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [SW-1:0]     wlow,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [SW-1:0]     status,
  input logic [SW-1:0]     mask,
  input logic [CNT_W-1:0]  cnt_src,
  input logic              irq
);
  logic [SW-1:0] clr_v;
  logic          pend;
  assign clr_v = (reg_wr && reg_addr == '0) ? wlow : '0;
  assign pend  = |(status & ~mask);

  // R1: mask comes out of reset fully set
  a_r1_mask_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> mask == '1);

  // R2 / R3: bits only drop where a one was written
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    (($past(status) & ~$past(clr_v)) & ~status) == '0);

  // R4: writes to the mask offset change nothing
  a_r4_mask_ro: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(1)) |=> mask == $past(mask));

  // R6: irq follows pending state with one register
  a_r6_irq_eq: assert property (@(posedge clk) disable iff (rst)
    irq == $past(pend));

  // R7: read of source counter leaves at most 1
  a_r7_cor: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_W'(4)) |=> cnt_src <= CNT_W'(1));

  // R9: unmapped access flags bit 0
  a_r9_invalid: assert property (@(posedge clk) disable iff (rst)
    ((reg_rd || reg_wr) && reg_addr > ADDR_W'(5)) |=> status[0]);

  // R10: no read, no data
  a_r10_rdata_idle: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> reg_rdata == '0);
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .SW(ST_W)
) chk_i (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .wlow(reg_wdata[ST_W-1:0]), .reg_rdata(reg_rdata), .status(status_q),
  .mask(mask_q), .cnt_src(cnt_q[0]), .irq(irq)
);

// File: tb/dma_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_irq_ctrl_tb_top;
  logic clk = 0, rst = 1;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic ev_done = 0, ev_pause = 0, ev_wr_err = 0, ev_rd_err = 0;
  logic ev_src_dscr_err = 0, ev_dst_dscr_err = 0, ev_byte_ovf = 0;
  logic ev_src_dscr_done = 0, ev_dst_dscr_done = 0;
  logic irq;

  always #5 clk = ~clk;

  dma_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_done(ev_done),
    .ev_pause(ev_pause), .ev_wr_err(ev_wr_err), .ev_rd_err(ev_rd_err),
    .ev_src_dscr_err(ev_src_dscr_err), .ev_dst_dscr_err(ev_dst_dscr_err),
    .ev_byte_ovf(ev_byte_ovf), .ev_src_dscr_done(ev_src_dscr_done),
    .ev_dst_dscr_done(ev_dst_dscr_done), .irq(irq)
  );

  int checks = 0, fails = 0;
  bit done_flag = 0;

  // ---------------- behavioural reference ----------------
  int m_st = 0, m_mk = 'hFFF, m_cs = 0, m_cd = 0, m_rdata = 0;
  bit m_irq = 0;
  string m_tag = "R10";

  function automatic string tag_of(int a);
    if (a == 0) return "R2";
    if (a == 1) return "R4";
    if (a == 2 || a == 3) return "R5";
    if (a == 4 || a == 5) return "R7";
    return "R9";
  endfunction

  always @(posedge clk) begin
    int set, clr, rv, a;
    a = reg_addr;
    if (rst) begin
      m_st = 0; m_mk = 'hFFF; m_cs = 0; m_cd = 0; m_rdata = 0; m_irq = 0;
      m_tag = "R1";
    end else begin
      rv = 0;
      if (reg_rd) begin
        case (a)
          0: rv = m_st;
          1: rv = m_mk;
          4: rv = m_cs;
          5: rv = m_cd;
          default: rv = 0;
        endcase
      end
      set = 0;
      if ((reg_rd || reg_wr) && a > 5) set |= 1;
      if (ev_src_dscr_done) set |= 1 << 1;
      if (ev_dst_dscr_done) set |= 1 << 2;
      if (ev_byte_ovf)      set |= 1 << 3;
      if (ev_src_dscr_err)  set |= 1 << 6;
      if (ev_dst_dscr_err)  set |= 1 << 7;
      if (ev_rd_err)        set |= 1 << 8;
      if (ev_wr_err)        set |= 1 << 9;
      if (ev_done)          set |= 1 << 10;
      if (ev_pause)         set |= 1 << 11;
      // counters
      if (reg_rd && a == 4) m_cs = ev_src_dscr_done ? 1 : 0;
      else if (ev_src_dscr_done) begin
        if (m_cs == 255) begin m_cs = 0; set |= 1 << 4; end else m_cs++;
      end
      if (reg_rd && a == 5) m_cd = ev_dst_dscr_done ? 1 : 0;
      else if (ev_dst_dscr_done) begin
        if (m_cd == 255) begin m_cd = 0; set |= 1 << 5; end else m_cd++;
      end
      m_irq = (m_st & ~m_mk & 'hFFF) != 0;
      clr = (reg_wr && a == 0) ? (reg_wdata & 'hFFF) : 0;
      m_st = (m_st & ~clr) | set;
      if (reg_wr && a == 2) m_mk = m_mk & ~(reg_wdata & 'hFFF);
      if (reg_wr && a == 3) m_mk = m_mk | (reg_wdata & 'hFFF);
      m_rdata = rv;
      m_tag = reg_rd ? tag_of(a) : "R10";
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      check("R6", int'(irq), int'(m_irq));
      check(m_tag, int'(reg_rdata), m_rdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(int a, int d);
    @(negedge clk); reg_wr = 1; reg_addr = a[3:0]; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk); reg_rd = 1; reg_addr = a[3:0];
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic src_incs(int n);
    @(negedge clk); ev_src_dscr_done = 1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); ev_src_dscr_done = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    done_flag = 1;
    summary();
    $finish;
  end

  initial begin
    int d;
    repeat (5) @(negedge clk);
    rst = 0;
    // R1 reset values
    check("R1", int'(irq), 0);
    check("R1", int'(reg_rdata), 0);
    rd(0, d); check("R1", d, 0);
    rd(1, d); check("R1", d, 'hFFF);
    rd(4, d); check("R1", d, 0);
    // R2 event sets sticky bit
    @(negedge clk); ev_done = 1; @(negedge clk); ev_done = 0;
    repeat (3) @(negedge clk);
    rd(0, d); check("R2", d, 'h400);
    // R3 clear, then clear racing an event
    wr(0, 'h400); rd(0, d); check("R3", d, 0);
    @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = 'h800; ev_pause = 1;
    @(negedge clk); reg_wr = 0; ev_pause = 0;
    rd(0, d); check("R3", d, 'h800);
    // R4 mask write ignored
    wr(1, 0); rd(1, d); check("R4", d, 'hFFF);
    // R5 unmask / mask, R6 irq
    wr(2, 'h800); rd(1, d); check("R5", d, 'h7FF);
    rd(2, d); check("R5", d, 0);
    @(negedge clk); check("R6", int'(irq), 1);
    wr(3, 'h800); rd(1, d); check("R5", d, 'hFFF);
    rd(3, d); check("R5", d, 0);
    @(negedge clk); check("R6", int'(irq), 0);
    wr(0, 'hFFF);
    // R7 counting and clear on read
    src_incs(3); rd(4, d); check("R7", d, 3);
    rd(4, d); check("R7", d, 0);
    @(negedge clk); reg_rd = 1; reg_addr = 5; ev_dst_dscr_done = 1;
    @(negedge clk); reg_rd = 0; ev_dst_dscr_done = 0;
    rd(5, d); check("R7", d, 1);
    // R8 wrap sets error bit 4
    wr(0, 'hFFF);
    src_incs(256); rd(4, d); check("R8", d, 0);
    rd(0, d); check("R8", d & 'h10, 'h10);
    // R8 read coinciding with the wrapping increment: no error
    wr(0, 'hFFF);
    src_incs(255);
    @(negedge clk); reg_rd = 1; reg_addr = 4; ev_src_dscr_done = 1;
    @(negedge clk); reg_rd = 0; ev_src_dscr_done = 0; check("R8", int'(reg_rdata), 255);
    rd(4, d); check("R8", d, 1);
    rd(0, d); check("R8", d & 'h10, 0);
    // R9 unmapped access
    wr(0, 'hFFF);
    rd(9, d); check("R9", d, 0);
    rd(0, d); check("R9", d & 1, 1);
    wr(0, 1); wr(14, 'h123); rd(0, d); check("R9", d & 1, 1);
    // random phase, checked by the per-clock comparison
    for (int i = 0; i < 4000; i++) begin
      int op;
      @(negedge clk);
      op = $urandom_range(0, 3);
      reg_rd = (op == 1); reg_wr = (op == 2);
      reg_addr = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(6, 15))
                                             : 4'($urandom_range(0, 5));
      reg_wdata = $urandom;
      ev_done          = ($urandom_range(0, 15) == 0);
      ev_pause         = ($urandom_range(0, 15) == 0);
      ev_wr_err        = ($urandom_range(0, 31) == 0);
      ev_rd_err        = ($urandom_range(0, 31) == 0);
      ev_src_dscr_err  = ($urandom_range(0, 31) == 0);
      ev_dst_dscr_err  = ($urandom_range(0, 31) == 0);
      ev_byte_ovf      = ($urandom_range(0, 31) == 0);
      ev_src_dscr_done = ($urandom_range(0, 1) == 0);
      ev_dst_dscr_done = ($urandom_range(0, 1) == 0);
    end
    @(negedge clk);
    reg_rd = 0; reg_wr = 0; ev_done = 0; ev_pause = 0; ev_wr_err = 0; ev_rd_err = 0;
    ev_src_dscr_err = 0; ev_dst_dscr_err = 0; ev_byte_ovf = 0;
    ev_src_dscr_done = 0; ev_dst_dscr_done = 0;
    repeat (3) @(negedge clk);
    done_flag = 1;
    summary();
    $finish;
  end
endmodule